// File: doc/BRIEF.md
# Exception Vector Dispatcher

This block sits beside a 32-bit core's pipeline and decides where control goes when a fault or a debug event is raised. It owns the exception-related status state: the user-mode, exception-mode and interrupt-level fields of the processor status word, the first-level exception PC, an optional separate PC register for double exceptions, the exception cause and faulting-address registers, the debug cause, and one saved PC / saved status pair for each interrupt level from 2 up to the highest level.

A general exception taken while exception mode is clear saves the PC to the first-level PC register. It then picks the user or kernel vector from the user-mode bit. A general exception taken while exception mode is already set is a double exception. Its PC goes to the double-exception PC register when that register is built in, and to the first-level register otherwise. A debug event is honoured only below the configured debug level. When honoured, it saves the PC and the old status into that level's pair, raises the interrupt level and selects the debug vector. The vector select and a one-cycle redirect strobe are registered. A status write port lets the core restore status after a handler, and a level-indexed read port exposes the saved pairs.

Top module: `exc_vector_dispatch`

## Requirements
- R1: After reset the status fields (user mode, exception mode, interrupt level) are zero, every saved register reads zero, `redirect_o` is low and `vec_o` is 0 (kernel).
- R2: A raise with exception mode clear stores `pc_i` in the first-level PC and selects vector 1 (user) when user mode is 1, else vector 0 (kernel).
- R3: Every taken raise writes `cause_i` to the exception cause register and sets exception mode.
- R4: A raise with exception mode already set selects vector 2 (double). With `HAS_DEPC`=1 the PC goes to the double PC register and the first-level PC is unchanged; with `HAS_DEPC`=0 the PC goes to the first-level PC.
- R5: A taken raise with `addr_valid_i` high writes `vaddr_i` to the faulting-address register; with it low that register keeps its value.
- R6: A debug event is accepted only when the interrupt level is strictly below `DEBUG_LEVEL`. Otherwise it produces no redirect and changes no register.
- R7: An accepted debug event writes `dbg_cause_i` to the debug cause and stores `pc_i` and the old status as the pair of level `DEBUG_LEVEL`. The saved status is packed as {user mode, exception mode, interrupt level[3:0]}. The event then sets the interrupt level to `DEBUG_LEVEL`, sets exception mode, keeps user mode and selects vector 3 (debug).
- R8: When a raise and an accepted debug event arrive together, the debug event is taken and the raise is dropped (exception cause unchanged). When the debug event is refused, the raise is taken.
- R9: `redirect_o` is high for exactly the cycle after the clock edge that takes an event, and low otherwise. `vec_o` keeps its value until the next taken event.
- R10: A status write loads the three status fields when no event is taken in that cycle; a taken event in the same cycle overrides it.
- R11: The read port returns the first-level PC with a zero status for level 1, the saved pair for levels 2 to `MAX_LEVEL`, and zeros for level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | 1 | General exception strobe |
| cause_i | input | CAUSE_W | Exception cause code |
| pc_i | input | PC_W | PC of the faulting instruction or debug event |
| addr_valid_i | input | 1 | The exception carries a faulting address |
| vaddr_i | input | PC_W | Faulting virtual address |
| dbg_i | input | 1 | Debug event strobe |
| dbg_cause_i | input | DCAUSE_W | Debug cause bits |
| ps_we_i | input | 1 | Status write enable |
| ps_um_i | input | 1 | User-mode value to write |
| ps_excm_i | input | 1 | Exception-mode value to write |
| ps_il_i | input | IL_W | Interrupt level to write |
| lvl_sel_i | input | SEL_W | Level selected on the read port |
| ps_um_o | output | 1 | Current user-mode bit |
| ps_excm_o | output | 1 | Current exception-mode bit |
| ps_il_o | output | IL_W | Current interrupt level |
| epc1_o | output | PC_W | First-level exception PC |
| depc_o | output | PC_W | Double-exception PC |
| exccause_o | output | CAUSE_W | Exception cause register |
| excvaddr_o | output | PC_W | Faulting-address register |
| dbgcause_o | output | DCAUSE_W | Debug cause register |
| lvl_epc_o | output | PC_W | Saved PC of the selected level |
| lvl_eps_o | output | IL_W+2 | Saved status of the selected level |
| vec_o | output | 2 | Vector select: 0 kernel, 1 user, 2 double, 3 debug |
| redirect_o | output | 1 | One-cycle redirect strobe |

## Verification
The bench builds two copies side by side on the same stimulus. One has the double PC register and debug level 6. The other has no double PC register and debug level 2. Because the two debug levels differ, a single interrupt level of 3 leaves a debug event accepted by one copy and refused by the other. That lets one combined raise-plus-debug stimulus exercise both arms of the priority rule. The missing double PC register in the second copy shows the fallback to the first-level PC on a double exception.

// File: rtl/exc_vector_dispatch.sv
module exc_vector_dispatch #(
  parameter int PC_W        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter int IL_W        = 4,
  parameter int MAX_LEVEL   = 7,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1,
  localparam int PS_W       = IL_W + 2,
  localparam int SEL_W      = $clog2(MAX_LEVEL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                raise_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic                addr_valid_i,
  input  logic [PC_W-1:0]     vaddr_i,
  input  logic                dbg_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic                ps_we_i,
  input  logic                ps_um_i,
  input  logic                ps_excm_i,
  input  logic [IL_W-1:0]     ps_il_i,
  input  logic [SEL_W-1:0]    lvl_sel_i,
  output logic                ps_um_o,
  output logic                ps_excm_o,
  output logic [IL_W-1:0]     ps_il_o,
  output logic [PC_W-1:0]     epc1_o,
  output logic [PC_W-1:0]     depc_o,
  output logic [CAUSE_W-1:0]  exccause_o,
  output logic [PC_W-1:0]     excvaddr_o,
  output logic [DCAUSE_W-1:0] dbgcause_o,
  output logic [PC_W-1:0]     lvl_epc_o,
  output logic [PS_W-1:0]     lvl_eps_o,
  output logic [1:0]          vec_o,
  output logic                redirect_o
);

  localparam logic [1:0] VEC_KERNEL = 2'd0;
  localparam logic [1:0] VEC_USER   = 2'd1;
  localparam logic [1:0] VEC_DOUBLE = 2'd2;
  localparam logic [1:0] VEC_DEBUG  = 2'd3;
  localparam logic [IL_W-1:0] DBG_IL = IL_W'(DEBUG_LEVEL);

  logic                um_q, excm_q;
  logic [IL_W-1:0]     il_q;
  logic [PC_W-1:0]     epc1_q, depc_q, excvaddr_q;
  logic [CAUSE_W-1:0]  exccause_q;
  logic [DCAUSE_W-1:0] dbgcause_q;
  logic [PC_W-1:0]     epc_q [2:MAX_LEVEL];
  logic [PS_W-1:0]     eps_q [2:MAX_LEVEL];
  logic [1:0]          vec_q;
  logic                redirect_q;

  wire dbg_take = dbg_i && (il_q < DBG_IL);
  wire exc_take = raise_i && !dbg_take;
  wire [PS_W-1:0] ps_now = {um_q, excm_q, il_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      um_q       <= 1'b0;
      excm_q     <= 1'b0;
      il_q       <= '0;
      epc1_q     <= '0;
      depc_q     <= '0;
      excvaddr_q <= '0;
      exccause_q <= '0;
      dbgcause_q <= '0;
      vec_q      <= VEC_KERNEL;
      redirect_q <= 1'b0;
      for (int l = 2; l <= MAX_LEVEL; l++) begin
        epc_q[l] <= '0;
        eps_q[l] <= '0;
      end
    end else begin
      redirect_q <= dbg_take || exc_take;
      if (dbg_take) begin
        dbgcause_q          <= dbg_cause_i;
        epc_q[DEBUG_LEVEL]  <= pc_i;
        eps_q[DEBUG_LEVEL]  <= ps_now;
        il_q                <= DBG_IL;
        excm_q              <= 1'b1;
        vec_q               <= VEC_DEBUG;
      end else if (exc_take) begin
        if (addr_valid_i) excvaddr_q <= vaddr_i;
        exccause_q <= cause_i;
        excm_q     <= 1'b1;
        if (excm_q) begin
          vec_q <= VEC_DOUBLE;
          if (HAS_DEPC) depc_q <= pc_i;
          else          epc1_q <= pc_i;
        end else begin
          epc1_q <= pc_i;
          vec_q  <= um_q ? VEC_USER : VEC_KERNEL;
        end
      end else if (ps_we_i) begin
        um_q   <= ps_um_i;
        excm_q <= ps_excm_i;
        il_q   <= ps_il_i;
      end
    end
  end

  always_comb begin
    lvl_epc_o = '0;
    lvl_eps_o = '0;
    if (lvl_sel_i == SEL_W'(1)) lvl_epc_o = epc1_q;
    for (int l = 2; l <= MAX_LEVEL; l++) begin
      if (lvl_sel_i == SEL_W'(l)) begin
        lvl_epc_o = epc_q[l];
        lvl_eps_o = eps_q[l];
      end
    end
  end

  assign ps_um_o    = um_q;
  assign ps_excm_o  = excm_q;
  assign ps_il_o    = il_q;
  assign epc1_o     = epc1_q;
  assign depc_o     = depc_q;
  assign exccause_o = exccause_q;
  assign excvaddr_o = excvaddr_q;
  assign dbgcause_o = dbgcause_q;
  assign vec_o      = vec_q;
  assign redirect_o = redirect_q;

endmodule

// File: rtl/exc_vector_dispatch_chk.sv
module exc_vector_dispatch_chk #(
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter int IL_W        = 4,
  parameter int DEBUG_LEVEL = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                raise_i,
  input logic                dbg_i,
  input logic                ps_we_i,
  input logic                ps_um_o,
  input logic                ps_excm_o,
  input logic [IL_W-1:0]     ps_il_o,
  input logic [CAUSE_W-1:0]  exccause_o,
  input logic [DCAUSE_W-1:0] dbgcause_o,
  input logic [1:0]          vec_o,
  input logic                redirect_o
);

  wire dbg_ok = dbg_i && (ps_il_o < IL_W'(DEBUG_LEVEL));

  // R9
  taken_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i || dbg_ok) |=> redirect_o);

  // R9
  idle_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(raise_i || dbg_ok) |=> !redirect_o);

  // R3
  redirect_excm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> ps_excm_o);

  // R7
  debug_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ok |=> (vec_o == 2'd3) && (ps_il_o == IL_W'(DEBUG_LEVEL)) && $stable(ps_um_o));

  // R4
  double_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && !dbg_ok && ps_excm_o) |=> vec_o == 2'd2);

  // R2
  first_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && !dbg_ok && !ps_excm_o) |=> vec_o == {1'b0, $past(ps_um_o)});

  // R6
  debug_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_i && !dbg_ok && !raise_i) |=> !redirect_o && $stable(dbgcause_o));

  // R8
  debug_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && dbg_ok) |=> $stable(exccause_o));

  // R10
  ps_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_we_i && !raise_i && !dbg_ok) |=> !redirect_o && $stable(vec_o));

endmodule

bind exc_vector_dispatch exc_vector_dispatch_chk #(
  .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .IL_W(IL_W), .DEBUG_LEVEL(DEBUG_LEVEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .dbg_i(dbg_i), .ps_we_i(ps_we_i),
  .ps_um_o(ps_um_o), .ps_excm_o(ps_excm_o), .ps_il_o(ps_il_o),
  .exccause_o(exccause_o), .dbgcause_o(dbgcause_o), .vec_o(vec_o),
  .redirect_o(redirect_o)
);

// File: tb/test_exc_vector_dispatch.sv
module test_exc_vector_dispatch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        raise_i = 0, addr_valid_i = 0, dbg_i = 0, ps_we_i = 0;
  logic        ps_um_i = 0, ps_excm_i = 0;
  logic [3:0]  ps_il_i = 0;
  logic [5:0]  cause_i = 0, dbg_cause_i = 0;
  logic [31:0] pc_i = 0, vaddr_i = 0;
  logic [2:0]  sel_a = 0, sel_b = 0;

  logic        um_a, excm_a, red_a, um_b, excm_b, red_b;
  logic [3:0]  il_a, il_b;
  logic [31:0] epc1_a, depc_a, va_a, lepc_a, epc1_b, depc_b, va_b, lepc_b;
  logic [5:0]  cc_a, dc_a, leps_a, cc_b, dc_b, leps_b;
  logic [1:0]  vec_a, vec_b;

  exc_vector_dispatch #(.DEBUG_LEVEL(6), .HAS_DEPC(1'b1)) i_exc_vector_dispatch (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .cause_i(cause_i), .pc_i(pc_i),
    .addr_valid_i(addr_valid_i), .vaddr_i(vaddr_i), .dbg_i(dbg_i),
    .dbg_cause_i(dbg_cause_i), .ps_we_i(ps_we_i), .ps_um_i(ps_um_i),
    .ps_excm_i(ps_excm_i), .ps_il_i(ps_il_i), .lvl_sel_i(sel_a),
    .ps_um_o(um_a), .ps_excm_o(excm_a), .ps_il_o(il_a), .epc1_o(epc1_a),
    .depc_o(depc_a), .exccause_o(cc_a), .excvaddr_o(va_a), .dbgcause_o(dc_a),
    .lvl_epc_o(lepc_a), .lvl_eps_o(leps_a), .vec_o(vec_a), .redirect_o(red_a));

  exc_vector_dispatch #(.DEBUG_LEVEL(2), .HAS_DEPC(1'b0)) i_exc_vector_dispatch_b (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .cause_i(cause_i), .pc_i(pc_i),
    .addr_valid_i(addr_valid_i), .vaddr_i(vaddr_i), .dbg_i(dbg_i),
    .dbg_cause_i(dbg_cause_i), .ps_we_i(ps_we_i), .ps_um_i(ps_um_i),
    .ps_excm_i(ps_excm_i), .ps_il_i(ps_il_i), .lvl_sel_i(sel_b),
    .ps_um_o(um_b), .ps_excm_o(excm_b), .ps_il_o(il_b), .epc1_o(epc1_b),
    .depc_o(depc_b), .exccause_o(cc_b), .excvaddr_o(va_b), .dbgcause_o(dc_b),
    .lvl_epc_o(lepc_b), .lvl_eps_o(leps_b), .vec_o(vec_b), .redirect_o(red_b));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ps_write(logic um, logic excm, logic [3:0] il);
    @(negedge clk);
    ps_we_i = 1; ps_um_i = um; ps_excm_i = excm; ps_il_i = il;
    @(negedge clk);
    ps_we_i = 0;
  endtask

  task automatic fire(logic r, logic d, logic [5:0] c, logic [5:0] dc,
                      logic [31:0] pc, logic av, logic [31:0] va);
    @(negedge clk);
    raise_i = r; dbg_i = d; cause_i = c; dbg_cause_i = dc;
    pc_i = pc; addr_valid_i = av; vaddr_i = va;
    @(negedge clk);
    raise_i = 0; dbg_i = 0; addr_valid_i = 0;
  endtask

  task automatic t_reset;
    check("R1", "um", um_a, 0);     check("R1", "excm", excm_a, 0);
    check("R1", "il", il_a, 0);     check("R1", "epc1", epc1_a, 0);
    check("R1", "depc", depc_a, 0); check("R1", "exccause", cc_a, 0);
    check("R1", "redirect", red_a, 0); check("R1", "vec", vec_a, 0);
    check("R1", "b redirect", red_b, 0);
  endtask

  task automatic t_kernel;
    fire(1, 0, 6'd5, 6'd0, 32'h1000, 1, 32'hDEAD0000);
    check("R9", "redirect high", red_a, 1);
    check("R2", "kernel vec", vec_a, 0);
    check("R2", "epc1", epc1_a, 32'h1000);
    check("R3", "exccause", cc_a, 5);
    check("R3", "excm", excm_a, 1);
    check("R5", "excvaddr", va_a, 32'hDEAD0000);
    check("R2", "b epc1", epc1_b, 32'h1000);
    @(negedge clk);
    check("R9", "redirect one cycle", red_a, 0);
    check("R9", "vec holds", vec_a, 0);
  endtask

  task automatic t_double;
    fire(1, 0, 6'd7, 6'd0, 32'h2000, 0, 32'h55555555);
    check("R4", "double vec", vec_a, 2);
    check("R4", "depc", depc_a, 32'h2000);
    check("R4", "epc1 kept", epc1_a, 32'h1000);
    check("R4", "b double vec", vec_b, 2);
    check("R4", "b epc1", epc1_b, 32'h2000);
    check("R4", "b depc zero", depc_b, 0);
    check("R5", "excvaddr kept", va_a, 32'hDEAD0000);
    check("R3", "exccause", cc_a, 7);
  endtask

  task automatic t_user;
    ps_write(1, 0, 4'd0);
    check("R10", "um loaded", um_a, 1);
    check("R10", "excm loaded", excm_a, 0);
    check("R10", "no redirect", red_a, 0);
    fire(1, 0, 6'd3, 6'd0, 32'h3000, 0, 32'h0);
    check("R2", "user vec", vec_a, 1);
    check("R2", "epc1", epc1_a, 32'h3000);
    check("R2", "b user vec", vec_b, 1);
  endtask

  task automatic t_debug;
    ps_write(1, 0, 4'd1);
    fire(0, 1, 6'd0, 6'h12, 32'h4000, 0, 32'h0);
    sel_a = 3'd6; sel_b = 3'd2;
    #1;
    check("R7", "vec debug", vec_a, 3);
    check("R7", "dbgcause", dc_a, 6'h12);
    check("R7", "il", il_a, 6);
    check("R7", "excm", excm_a, 1);
    check("R7", "um kept", um_a, 1);
    check("R7", "epc lvl6", lepc_a, 32'h4000);
    check("R7", "eps lvl6", leps_a, 6'h21);
    check("R7", "b il", il_b, 2);
    check("R7", "b epc lvl2", lepc_b, 32'h4000);
    check("R7", "b eps lvl2", leps_b, 6'h21);
  endtask

  task automatic t_refused;
    fire(0, 1, 6'd0, 6'h05, 32'h5000, 0, 32'h0);
    #1;
    check("R6", "no redirect", red_a, 0);
    check("R6", "b no redirect", red_b, 0);
    check("R6", "dbgcause kept", dc_a, 6'h12);
    check("R6", "b dbgcause kept", dc_b, 6'h12);
    check("R6", "epc lvl6 kept", lepc_a, 32'h4000);
  endtask

  task automatic t_both;
    ps_write(0, 0, 4'd0);
    fire(1, 1, 6'd9, 6'h21, 32'h6000, 0, 32'h0);
    check("R8", "debug wins vec", vec_a, 3);
    check("R8", "exccause kept", cc_a, 3);
    check("R8", "dbgcause", dc_a, 6'h21);
    check("R8", "b debug wins", vec_b, 3);
    ps_write(0, 0, 4'd3);
    fire(1, 1, 6'hA, 6'h2A, 32'h7000, 0, 32'h0);
    check("R8", "a debug taken", vec_a, 3);
    check("R8", "a exccause kept", cc_a, 3);
    check("R8", "b raise taken vec", vec_b, 0);
    check("R8", "b exccause", cc_b, 6'hA);
    check("R8", "b epc1", epc1_b, 32'h7000);
    check("R8", "b dbgcause kept", dc_b, 6'h21);
  endtask

  task automatic t_override;
    @(negedge clk);
    ps_we_i = 1; ps_um_i = 1; ps_excm_i = 0; ps_il_i = 0;
    raise_i = 1; cause_i = 6'hB; pc_i = 32'h8000;
    @(negedge clk);
    ps_we_i = 0; raise_i = 0;
    check("R10", "um not loaded", um_a, 0);
    check("R10", "il not loaded", il_a, 6);
    check("R4", "double after override", vec_a, 2);
    check("R4", "depc", depc_a, 32'h8000);
    check("R4", "b epc1", epc1_b, 32'h8000);
  endtask

  task automatic t_read;
    sel_a = 3'd1; sel_b = 3'd1;
    #1;
    check("R11", "lvl1 epc", lepc_a, 32'h3000);
    check("R11", "lvl1 eps", leps_a, 0);
    check("R11", "b lvl1 epc", lepc_b, 32'h8000);
    sel_a = 3'd0;
    #1;
    check("R11", "lvl0 epc", lepc_a, 0);
    check("R11", "lvl0 eps", leps_a, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_kernel();
    t_double();
    t_user();
    t_debug();
    t_refused();
    t_both();
    t_override();
    t_read();
    finish_run();
  end
endmodule